// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupt Detection

This block is a general-purpose I/O controller organised as a parameterised number of 32-pin banks behind a simple word-addressed register bus. Each bank holds eight 32-bit registers. They set the pin direction, the output value and open-drain mode, and they select a trigger type for each pin: active-high level, active-low level, rising edge, falling edge or either edge. The block drives each output pin, returns the live pad value of each input pin, and latches detected events in a per-pin status bit. Software clears a status bit by writing 1 to it.

Every bank may be given its own width, from 0 to 32 pins. A narrower bank still takes a full eight-word slot in the address map, so the bank offsets do not change. Pending events are the status bits whose mask bit is set. All pending events, across every bank, are merged into a single interrupt output.

Top module: `gpio_multibank`

## Requirements
- R1: After reset every register reads zero. Every valid pin drives 0 with its output enable on, and `irq` is low.
- R2: The word address selects bank `addr[ADDR_W-1:3]` and register `addr[2:0]`. The register indices are: 0 open-drain enable, 1 data, 2 direction, 3 polarity, 4 either-edge, 5 mask, 6 level select, 7 status. Read data appears on `bus_rdata` one cycle after the read is issued.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. A data read returns the synchronised pad value for input bits and the written data for output bits.
- R4: An output pin with open-drain enabled drives low (`pin_oe`=1, `pin_out`=0) when its data bit is 0, and releases (`pin_oe`=0) when its data bit is 1.
- R5: With level select 0 and either-edge 0, polarity 1 latches status on a rising pad edge and polarity 0 latches on a falling edge. The opposite edge sets nothing.
- R6: With level select 0 and either-edge 1, both edges latch status and polarity is ignored.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it as it is.
- R8: Status latches even while the pin is masked, so `irq` rises as soon as the mask bit is set.
- R9: With level select 1, status is set on every cycle the pad is at the active level (polarity 1 means high, 0 means low). A clear only takes effect once the pad has gone inactive.
- R10: Bits at or above a bank's width, a bank of width 0, and addresses beyond the last bank read zero and never drive or latch.
- R11: `irq` is the OR over all banks of status AND mask.
- R12: A pad change shows in status two clock edges after the edge that samples it. Edge detection compares the synchronised value with its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_BANKS*32 | Pad input values |
| pin_out | output | NUM_BANKS*32 | Pad output values |
| pin_oe | output | NUM_BANKS*32 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions are evaluated on every cycle and cover the following: an event always lands in status, and status bits fall only through a status write. A written 1 clears a bit unless an event arrives in the same cycle. Open-drain pins never drive high. Unused bit positions stay silent. `irq` always matches the OR of masked status. Only the bench scenarios can show each trigger type responding to the right edge or level and ignoring the opposite one. The same holds for the data read mux that mixes pad and register values, for the address decode across a zero-width bank and out-of-range addresses, and for a level source re-asserting status after a clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BANK_BITS = 32;
  localparam int REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    RG_OPEN_DRAIN = 3'd0,
    RG_DATA       = 3'd1,
    RG_DIR        = 3'd2,
    RG_POLARITY   = 3'd3,
    RG_ANY_EDGE   = 3'd4,
    RG_MASK       = 3'd5,
    RG_LEVEL      = 3'd6,
    RG_STATUS     = 3'd7
  } reg_idx_e;

  function automatic logic [BANK_BITS-1:0] width_mask(input int unsigned w);
    if (w >= BANK_BITS) return '1;
    return (32'h1 << w) - 32'h1;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sampled,
  input  logic [W-1:0] valid,
  input  logic [W-1:0] level_sel,
  input  logic [W-1:0] polarity,
  input  logic [W-1:0] any_edge,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] evt_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sampled;
  end

  assign rise = sampled & ~prev_q;
  assign fall = ~sampled & prev_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (level_sel[i])     evt_raw[i] = polarity[i] ? sampled[i] : ~sampled[i];
      else if (any_edge[i]) evt_raw[i] = rise[i] | fall[i];
      else                  evt_raw[i] = polarity[i] ? rise[i] : fall[i];
    end
  end

  assign evt = evt_raw & valid;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] wr_sel,
  input  logic [BANK_BITS-1:0] wdata,
  input  logic [REG_SEL_W-1:0] rd_sel,
  output logic [BANK_BITS-1:0] rd_word,
  input  logic [BANK_BITS-1:0] pad_in,
  output logic [BANK_BITS-1:0] pad_out,
  output logic [BANK_BITS-1:0] pad_oe,
  output logic                 bank_irq,
  output logic [BANK_BITS-1:0] stat_o,
  output logic [BANK_BITS-1:0] mask_o,
  output logic [BANK_BITS-1:0] evt_o,
  output logic [BANK_BITS-1:0] oden_o
);
  localparam logic [BANK_BITS-1:0] VALID = width_mask(WIDTH);

  logic [BANK_BITS-1:0] oden_q, data_q, dir_q, pol_q, any_q, mask_q, lvl_q, stat_q;
  logic [BANK_BITS-1:0] oden_d, data_d, dir_d, pol_d, any_d, mask_d, lvl_d, stat_d;
  logic [BANK_BITS-1:0] wmask;
  logic [BANK_BITS-1:0] pad_sync;
  logic [BANK_BITS-1:0] evt;

  gpio_sync2 #(.W(BANK_BITS)) sync_i (
    .clk (clk),
    .rst_n (rst_n),
    .d   (pad_in & VALID),
    .q   (pad_sync)
  );

  gpio_trigger #(.W(BANK_BITS)) trig_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sampled   (pad_sync),
    .valid     (VALID),
    .level_sel (lvl_q),
    .polarity  (pol_q),
    .any_edge  (any_q),
    .evt       (evt)
  );

  assign wmask = wdata & VALID;

  always_comb begin
    oden_d = oden_q;
    data_d = data_q;
    dir_d  = dir_q;
    pol_d  = pol_q;
    any_d  = any_q;
    mask_d = mask_q;
    lvl_d  = lvl_q;
    stat_d = stat_q;
    if (wr_en) begin
      unique case (reg_idx_e'(wr_sel))
        RG_OPEN_DRAIN: oden_d = wmask;
        RG_DATA:       data_d = wmask;
        RG_DIR:        dir_d  = wmask;
        RG_POLARITY:   pol_d  = wmask;
        RG_ANY_EDGE:   any_d  = wmask;
        RG_MASK:       mask_d = wmask;
        RG_LEVEL:      lvl_d  = wmask;
        RG_STATUS:     stat_d = stat_q & ~wmask;
        default:       ;
      endcase
    end
    stat_d = stat_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oden_q <= '0;
      data_q <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
      stat_q <= '0;
    end else begin
      oden_q <= oden_d;
      data_q <= data_d;
      dir_q  <= dir_d;
      pol_q  <= pol_d;
      any_q  <= any_d;
      mask_q <= mask_d;
      lvl_q  <= lvl_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    unique case (reg_idx_e'(rd_sel))
      RG_OPEN_DRAIN: rd_word = oden_q;
      RG_DATA:       rd_word = (dir_q & pad_sync) | (~dir_q & data_q);
      RG_DIR:        rd_word = dir_q;
      RG_POLARITY:   rd_word = pol_q;
      RG_ANY_EDGE:   rd_word = any_q;
      RG_MASK:       rd_word = mask_q;
      RG_LEVEL:      rd_word = lvl_q;
      RG_STATUS:     rd_word = stat_q;
      default:       rd_word = '0;
    endcase
  end

  assign pad_oe   = VALID & ~dir_q & ~(oden_q & data_q);
  assign pad_out  = VALID & data_q & ~oden_q;
  assign bank_irq = |(stat_q & mask_q);
  assign stat_o   = stat_q;
  assign mask_o   = mask_q;
  assign evt_o    = evt;
  assign oden_o   = oden_q;
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd12, 6'd0, 6'd32},
  localparam int PINS     = NUM_BANKS * BANK_BITS,
  localparam int BIDX_W   = ADDR_W - REG_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  logic [BIDX_W-1:0]    bank_idx;
  logic [REG_SEL_W-1:0] reg_sel;
  logic                 in_range;
  logic                 rd_en;
  logic [31:0]          rdata_d;
  logic [31:0]          rdata_q;
  logic [31:0]          rd_words [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;
  logic [PINS-1:0]      stat_all, mask_all, evt_all, oden_all;

  assign bank_idx = bus_addr[ADDR_W-1:REG_SEL_W];
  assign reg_sel  = bus_addr[REG_SEL_W-1:0];
  assign in_range = ({1'b0, bank_idx} < (BIDX_W+1)'(NUM_BANKS));
  assign rd_en    = bus_sel & ~bus_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW = int'(BANK_WIDTHS[b*6 +: 6]);
    logic wr_en;
    assign wr_en = bus_sel & bus_we & in_range & (bank_idx == BIDX_W'(b));

    gpio_bank #(.WIDTH(BW)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (reg_sel),
      .wdata    (bus_wdata),
      .rd_sel   (reg_sel),
      .rd_word  (rd_words[b]),
      .pad_in   (pin_in[b*BANK_BITS +: BANK_BITS]),
      .pad_out  (pin_out[b*BANK_BITS +: BANK_BITS]),
      .pad_oe   (pin_oe[b*BANK_BITS +: BANK_BITS]),
      .bank_irq (bank_irq[b]),
      .stat_o   (stat_all[b*BANK_BITS +: BANK_BITS]),
      .mask_o   (mask_all[b*BANK_BITS +: BANK_BITS]),
      .evt_o    (evt_all[b*BANK_BITS +: BANK_BITS]),
      .oden_o   (oden_all[b*BANK_BITS +: BANK_BITS])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (in_range && bank_idx == BIDX_W'(b)) rdata_d = rd_words[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq       = |bank_irq;
endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd12, 6'd0, 6'd32},
  localparam int PINS     = NUM_BANKS * BANK_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic              irq,
  input logic [PINS-1:0]   stat_all,
  input logic [PINS-1:0]   mask_all,
  input logic [PINS-1:0]   evt_all,
  input logic [PINS-1:0]   oden_all
);
  function automatic logic [PINS-1:0] all_valid();
    logic [PINS-1:0] v;
    for (int b = 0; b < NUM_BANKS; b++)
      v[b*BANK_BITS +: BANK_BITS] = width_mask(int'(BANK_WIDTHS[b*6 +: 6]));
    return v;
  endfunction

  localparam logic [PINS-1:0] VALID = all_valid();

  logic stat_wr;
  logic bank0_wr;
  assign stat_wr  = bus_sel && bus_we && (bus_addr[REG_SEL_W-1:0] == 3'd7);
  assign bank0_wr = stat_wr && (bus_addr[ADDR_W-1:REG_SEL_W] == '0);

  a_r5_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all != '0) |=> ((stat_all & $past(evt_all)) == $past(evt_all)));

  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_all & $past(stat_all)) == $past(stat_all)));

  a_r7_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_wr && bus_wdata[0] && !evt_all[0] && VALID[0]) |=> !stat_all[0]);

  a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_out & oden_all) == '0);

  a_r10_unused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out | stat_all) & ~VALID) == '0);

  a_r11_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat_all & mask_all));
endmodule

bind gpio_multibank gpio_multibank_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .ADDR_W      (ADDR_W),
  .BANK_WIDTHS (BANK_WIDTHS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .stat_all  (stat_all),
  .mask_all  (mask_all),
  .evt_all   (evt_all),
  .oden_all  (oden_all)
);

// File: tb/gpio_multibank_tb_top.sv
`timescale 1ns/1ps
module gpio_multibank_tb_top;
  localparam int NB = 3;
  localparam int AW = 8;
  localparam int P  = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [P-1:0]  pin_in = '0;
  logic [P-1:0]  pin_out;
  logic [P-1:0]  pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        was_rd = 1'b0;

  always #2.5 clk = ~clk;

  gpio_multibank dut_i (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
  );

  task automatic check(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: compares each read result the cycle after issue
  always @(posedge clk) was_rd <= bus_sel & ~bus_we;
  initial begin
    forever begin
      @(negedge clk);
      if (was_rd) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, P'(bus_rdata), P'(e));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", pin_oe, {32'h0000_0FFF, 32'h0, 32'hFFFF_FFFF});
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", P'(irq), '0);
    for (int r = 0; r < 8; r++) bus_read(r, 32'h0, "R1 reg reset");

    // R2/R4 open drain, register order
    bus_write(1, 32'h0000_00A5);
    bus_write(0, 32'h0000_0081);
    @(negedge clk);
    check("R4 od out", P'(pin_out[31:0]), P'(32'h0000_0024));
    check("R4 od oe", P'(pin_oe[31:0]), P'(32'hFFFF_FF7E));
    bus_read(0, 32'h0000_0081, "R2 oden readback");
    bus_write(1, 32'h0);
    @(negedge clk);
    check("R4 od drive low", P'(pin_oe[31:0]), P'(32'hFFFF_FFFF));
    bus_write(0, 32'h0);

    // R3 direction and data mix
    pin_in[31:0] = 32'hABCD_0000;
    bus_write(1, 32'h1234_5678);
    bus_write(2, 32'hFFFF_0000);
    settle();
    bus_read(1, 32'hABCD_5678, "R3 data mix");
    check("R3 oe by dir", P'(pin_oe[31:0]), P'(32'h0000_FFFF));
    bus_write(2, 32'h0);
    bus_write(1, 32'h0);

    // R10 width handling
    bus_write(17, 32'hFFFF_FFFF);
    bus_write(9, 32'hFFFF_FFFF);
    bus_read(17, 32'h0000_0FFF, "R10 narrow bank data");
    bus_read(9, 32'h0, "R10 empty bank");
    bus_read(25, 32'h0, "R10 out of range");
    check("R10 empty bank pins", P'(pin_oe[63:32] | pin_out[63:32]), '0);
    bus_write(17, 32'h0);

    // interrupt setup on bank 0 pins 0..4
    pin_in[31:0] = 32'h0000_0012;
    settle();
    bus_write(3, 32'h0000_0009);
    bus_write(4, 32'h0000_0004);
    bus_write(6, 32'h0000_0018);
    bus_write(5, 32'h0000_001F);
    bus_write(7, 32'hFFFF_FFFF);
    bus_write(23, 32'hFFFF_FFFF);
    bus_read(7, 32'h0, "R7 clear all");
    check("R11 irq idle", P'(irq), '0);

    // R5 rising
    pin_in[0] = 1'b1; settle();
    bus_read(7, 32'h1, "R5 rising latched");
    check("R11 irq rising", P'(irq), P'(1));
    bus_write(7, 32'h1);
    pin_in[0] = 1'b0; settle();
    bus_read(7, 32'h0, "R5 falling ignored on rising pin");
    // R5 falling
    pin_in[1] = 1'b0; settle();
    bus_read(7, 32'h2, "R5 falling latched");
    bus_write(7, 32'h2);
    pin_in[1] = 1'b1; settle();
    bus_read(7, 32'h0, "R5 rising ignored on falling pin");
    // R6 both
    pin_in[2] = 1'b1; settle();
    bus_read(7, 32'h4, "R6 rise");
    bus_write(7, 32'h4);
    pin_in[2] = 1'b0; settle();
    bus_read(7, 32'h4, "R6 fall");
    bus_write(7, 32'h4);
    // R7 w1c
    pin_in[0] = 1'b1; settle();
    bus_write(7, 32'h0);
    bus_read(7, 32'h1, "R7 zero write keeps");
    bus_write(7, 32'h1);
    bus_read(7, 32'h0, "R7 one write clears");
    check("R7 irq after clear", P'(irq), '0);
    // R8 masked latch
    bus_write(5, 32'h0000_001E);
    pin_in[0] = 1'b0; settle();
    pin_in[0] = 1'b1; settle();
    check("R8 masked irq low", P'(irq), '0);
    bus_read(7, 32'h1, "R8 masked status latched");
    bus_write(5, 32'h0000_001F);
    check("R8 unmask raises irq", P'(irq), P'(1));
    bus_write(7, 32'h1);
    // R9 level high
    pin_in[3] = 1'b1; settle();
    bus_read(7, 32'h8, "R9 level high set");
    bus_write(7, 32'h8);
    bus_read(7, 32'h8, "R9 level re-asserts");
    pin_in[3] = 1'b0; settle();
    bus_write(7, 32'h8);
    bus_read(7, 32'h0, "R9 clear after inactive");
    // R9 level low
    pin_in[4] = 1'b0; settle();
    bus_read(7, 32'h10, "R9 level low set");
    pin_in[4] = 1'b1; settle();
    bus_write(7, 32'h10);
    bus_read(7, 32'h0, "R9 level low cleared");
    check("R11 irq quiet", P'(irq), '0);

    // R12 latency: status appears two edges after sampling edge
    pin_in[0] = 1'b0; settle();
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R12 not yet", P'(irq), '0);
    @(negedge clk);
    check("R12 latched", P'(irq), P'(1));
    bus_write(7, 32'h1);

    // R11 / R10 on narrow bank 2
    bus_write(19, 32'h1);
    bus_write(21, 32'h1);
    pin_in[76] = 1'b1; settle();
    pin_in[76] = 1'b0; settle();
    bus_read(23, 32'h0, "R10 unused pin no latch");
    pin_in[64] = 1'b1; settle();
    check("R11 bank2 irq", P'(irq), P'(1));
    bus_read(23, 32'h1, "R11 bank2 status");
    bus_write(23, 32'h1);
    check("R11 bank2 irq cleared", P'(irq), '0);

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule